// File: doc/BRIEF.md
# Pre/post-trigger capture sequencer

This block runs one acquisition of a 16-channel logic analyzer. A run command latches the sample configuration and starts a sample strobe derived from the core clock through a 16-bit divider. The block first collects a pre-trigger quota of samples. It then keeps sampling while it waits for a trigger pulse. After the trigger it captures until the running sample total reaches the configured limit, and then it drops back to idle.

A 16-bit run-status word reports the phase. The upper twelve bits are fixed at 0x85e. The low nibble encodes the phase. Bit 0 set means idle. Bit 1 set means sample memory is being written. Bit 2 set means the trigger has been seen. Bit 3 set means the pre-trigger quota is complete.

The memory itself sits outside the block. Each sample is signalled by a one-cycle write strobe. The strobe has no ready input, so the memory must accept every strobe. The block also exposes the number of samples taken since the last start and the sample index at which the trigger was accepted.

Top module: `acq_sequencer`

## Requirements
- R1: After reset the status word is 0x85ed, the sample count and trigger index are 0, and the write strobe is low.
- R2: A command with mode 0x03 latches the 40-bit total limit, the 40-bit pre-trigger count and the divider, and clears the sample count and trigger index. On the next cycle the status is 0x85e2 if the pre-trigger count is non-zero, or 0x85ea if it is zero.
- R3: While not idle, the write strobe pulses once every D cycles, where D is the latched divider and a divider of 0 counts as 1. Each pulse adds one to the sample count. In idle the strobe is never high.
- R4: During pre-fill, the sample that brings the count to the pre-trigger count moves the status to 0x85ea. Trigger pulses during pre-fill are ignored.
- R5: While waiting, sampling goes on. A trigger pulse moves the status to 0x85ee and latches the trigger index, which is the sample count including any sample taken in that same cycle.
- R6: After the trigger, the first sample that leaves the count at or above the total limit returns the status to 0x85ed. At least one post-trigger sample is always taken, so the final count is the larger of the limit and the trigger index plus one. The count and trigger index then hold.
- R7: A command with mode 0x00 returns the block to idle (0x85ed) from any phase. The strobe stops and the counts hold.
- R8: A command with any mode other than 0x00 or 0x03 has no effect on status, strobe or counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle run-mode command strobe |
| cmd_mode | input | 8 | Run mode: 0x03 start, 0x00 halt |
| cfg_total | input | 40 | Total sample limit, latched on start |
| cfg_pre | input | 40 | Pre-trigger sample count, latched on start |
| cfg_div | input | 16 | Clock divider, latched on start (0 means 1) |
| trig_in | input | 1 | Trigger pulse |
| smp_we | output | 1 | Sample write strobe |
| run_status | output | 16 | Run-status word |
| smp_count | output | 40 | Samples taken since the last start |
| trig_index | output | 40 | Sample count latched at the trigger |

## Verification
The hardest cases are the cycle boundaries between phases. One is a trigger that arrives in the same cycle as the sample that completes the pre-fill. Another is a trigger that coincides with a strobe, which changes the latched index by one. The stimulus polls the status word away from the clock edge and applies the trigger a set number of cycles after the waiting code appears. It uses divider values that put strobes on and off the trigger cycle. A separate strobe counter in the bench gives the expected index and the expected final count.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_FILL = 2'd1,
    PH_ARM  = 2'd2,
    PH_POST = 2'd3
  } phase_t;

  localparam logic [7:0]  MODE_RUN  = 8'h03;
  localparam logic [7:0]  MODE_HALT = 8'h00;
  localparam logic [11:0] STAT_HEAD = 12'h85e;
  localparam logic [3:0]  NIB_IDLE  = 4'hd;
  localparam logic [3:0]  NIB_FILL  = 4'h2;
  localparam logic [3:0]  NIB_ARM   = 4'ha;
  localparam logic [3:0]  NIB_POST  = 4'he;
endpackage

// File: rtl/acq_clkdiv.sv
module acq_clkdiv #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  input  logic             run,
  output logic             tick
);
  logic [DIV_W-1:0] div_r;
  logic [DIV_W-1:0] cnt_r;
  logic             at_end;

  assign at_end = (cnt_r == div_r - DIV_W'(1));
  assign tick   = run && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_r <= DIV_W'(1);
      cnt_r <= '0;
    end else if (load) begin
      div_r <= (div_in == '0) ? DIV_W'(1) : div_in;
      cnt_r <= '0;
    end else if (run) begin
      cnt_r <= at_end ? '0 : cnt_r + DIV_W'(1);
    end
  end

  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_r < div_r); // R3
endmodule

// File: rtl/acq_ctrl.sv
module acq_ctrl
  import acq_pkg::*;
#(
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             halt,
  input  logic [CNT_W-1:0] cfg_total,
  input  logic [CNT_W-1:0] cfg_pre,
  input  logic             trig_in,
  input  logic             tick,
  output phase_t           phase,
  output logic             running,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] tidx
);
  logic [CNT_W-1:0] total_r;
  logic [CNT_W-1:0] pre_r;
  logic [CNT_W-1:0] cnt_inc;

  assign running = (phase != PH_IDLE);
  assign cnt_inc = count + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      count   <= '0;
      tidx    <= '0;
      total_r <= '0;
      pre_r   <= '0;
    end else if (start) begin
      total_r <= cfg_total;
      pre_r   <= cfg_pre;
      count   <= '0;
      tidx    <= '0;
      phase   <= (cfg_pre == '0) ? PH_ARM : PH_FILL;
    end else begin
      if (running && tick) count <= cnt_inc;
      if (halt) begin
        phase <= PH_IDLE;
      end else begin
        unique case (phase)
          PH_FILL: if (tick && cnt_inc >= pre_r) phase <= PH_ARM;
          PH_ARM: if (trig_in) begin
            phase <= PH_POST;
            tidx  <= tick ? cnt_inc : count;
          end
          PH_POST: if (tick && cnt_inc >= total_r) phase <= PH_IDLE;
          default: ;
        endcase
      end
    end
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && !start) |=> count == $past(count) + CNT_W'(1)); // R3
  AST_HALT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !start) |=> phase == PH_IDLE); // R7
  AST_FILL_NO_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FILL && trig_in && !start) |=> phase != PH_POST); // R4
  AST_TIDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_POST && !start) |=> $stable(tidx)); // R5
endmodule

// File: rtl/acq_status.sv
module acq_status
  import acq_pkg::*;
(
  input  phase_t      phase,
  output logic [15:0] word
);
  logic [3:0] nib;

  always_comb begin
    unique case (phase)
      PH_FILL: nib = NIB_FILL;
      PH_ARM:  nib = NIB_ARM;
      PH_POST: nib = NIB_POST;
      default: nib = NIB_IDLE;
    endcase
  end

  assign word = {STAT_HEAD, nib};
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
  import acq_pkg::*;
#(
  parameter int CNT_W = 40,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_mode,
  input  logic [CNT_W-1:0] cfg_total,
  input  logic [CNT_W-1:0] cfg_pre,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             trig_in,
  output logic             smp_we,
  output logic [15:0]      run_status,
  output logic [CNT_W-1:0] smp_count,
  output logic [CNT_W-1:0] trig_index
);
  logic   start, halt, running, tick;
  phase_t phase;

  assign start  = cmd_valid && (cmd_mode == MODE_RUN);
  assign halt   = cmd_valid && (cmd_mode == MODE_HALT);
  assign smp_we = tick;

  acq_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .load(start), .div_in(cfg_div),
    .run(running), .tick(tick)
  );

  acq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .halt(halt),
    .cfg_total(cfg_total), .cfg_pre(cfg_pre), .trig_in(trig_in),
    .tick(tick), .phase(phase), .running(running),
    .count(smp_count), .tidx(trig_index)
  );

  acq_status u_stat (.phase(phase), .word(run_status));

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    run_status[0] |-> !smp_we); // R3
endmodule

// File: tb/test_acq_sequencer.sv
`timescale 1ns/1ps
module test_acq_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_mode = 8'h00;
  logic [39:0] cfg_total = '0;
  logic [39:0] cfg_pre = '0;
  logic [15:0] cfg_div = '0;
  logic        trig_in = 1'b0;
  logic        smp_we;
  logic [15:0] run_status;
  logic [39:0] smp_count;
  logic [39:0] trig_index;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  longint mdl_cnt = 0;
  longint cyc = 0;
  longint last_we = 0;
  bit gap_arm = 0;
  int exp_gap = 1;

  localparam logic [15:0] S_IDLE = 16'h85ed;
  localparam logic [15:0] S_FILL = 16'h85e2;
  localparam logic [15:0] S_ARM  = 16'h85ea;
  localparam logic [15:0] S_POST = 16'h85ee;

  // {total, pre, divider, trigger delay after armed}
  localparam int NV = 5;
  localparam logic [111:0] VEC [NV] = '{
    {40'd20, 40'd5, 16'd1, 16'd3},
    {40'd10, 40'd4, 16'd3, 16'd0},
    {40'd8,  40'd0, 16'd2, 16'd5},
    {40'd6,  40'd6, 16'd0, 16'd2},
    {40'd12, 40'd2, 16'd4, 16'd1}
  };

  always #2.5 clk = ~clk;

  acq_sequencer i_acq_sequencer (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .cfg_total(cfg_total), .cfg_pre(cfg_pre), .cfg_div(cfg_div),
    .trig_in(trig_in), .smp_we(smp_we), .run_status(run_status),
    .smp_count(smp_count), .trig_index(trig_index)
  );

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // independent strobe model: counts strobes, checks their spacing (R3)
  always @(negedge clk) begin
    cyc++;
    if (smp_we) begin
      mdl_cnt++;
      if (gap_arm) check("R3 strobe spacing", cyc - last_we, exp_gap);
      last_we = cyc;
      gap_arm = 1;
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic command(logic [7:0] m);
    cmd_valid = 1'b1;
    cmd_mode  = m;
    step();
    cmd_valid = 1'b0;
  endtask

  task automatic start_run(logic [39:0] t, logic [39:0] p, logic [15:0] d);
    cfg_total = t;
    cfg_pre   = p;
    cfg_div   = d;
    mdl_cnt   = 0;
    gap_arm   = 0;
    exp_gap   = (d == 0) ? 1 : int'(d);
    command(8'h03);
  endtask

  task automatic wait_status(logic [15:0] s);
    for (int g = 0; g < 2000 && run_status != s; g++) step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    longint tidx;
    longint fin;
    repeat (3) step();
    // R1 reset state
    check("R1 status", run_status, S_IDLE);
    check("R1 count", smp_count, 0);
    check("R1 index", trig_index, 0);
    check("R1 strobe", smp_we, 0);
    rst_n = 1'b1;
    step();

    for (int v = 0; v < NV; v++) begin
      logic [39:0] t, p;
      logic [15:0] d, dl;
      {t, p, d, dl} = VEC[v];
      start_run(t, p, d);
      check("R2 start status", run_status, (p == 0) ? S_ARM : S_FILL);
      check("R2 count cleared", smp_count, mdl_cnt);
      wait_status(S_ARM);
      check("R4 pre quota", smp_count, p);
      check("R4 model quota", mdl_cnt, p);
      for (int k = 0; k < int'(dl); k++) step();
      check("R5 sampling while armed", smp_count, mdl_cnt);
      trig_in = 1'b1;
      step();
      trig_in = 1'b0;
      tidx = mdl_cnt;
      check("R5 post status", run_status, S_POST);
      check("R5 trigger index", trig_index, tidx);
      wait_status(S_IDLE);
      fin = (tidx + 1 > longint'(t)) ? tidx + 1 : longint'(t);
      check("R6 final count", smp_count, fin);
      check("R6 model count", mdl_cnt, fin);
      repeat (4) step();
      check("R6 count holds", smp_count, fin);
      check("R6 index holds", trig_index, tidx);
      check("R6 idle status", run_status, S_IDLE);
    end

    // R8: unknown mode while idle
    fin = smp_count;
    command(8'h01);
    step();
    check("R8 idle status unchanged", run_status, S_IDLE);
    check("R8 idle count unchanged", smp_count, fin);

    // R4 trigger during pre-fill ignored, R8 unknown mode during run, R7 halt
    start_run(40'd500, 40'd200, 16'd2);
    repeat (5) step();
    command(8'h05);
    check("R8 run status unchanged", run_status, S_FILL);
    check("R8 run count tracks", smp_count, mdl_cnt);
    trig_in = 1'b1;
    step();
    trig_in = 1'b0;
    step();
    check("R4 trigger ignored", run_status, S_FILL);
    check("R4 index untouched", trig_index, 0);
    command(8'h00);
    check("R7 halt status", run_status, S_IDLE);
    fin = mdl_cnt;
    check("R7 count at halt", smp_count, fin);
    repeat (6) step();
    check("R7 strobe stopped", mdl_cnt, fin);
    check("R7 count holds", smp_count, fin);

    // R4 trigger on the cycle that completes the pre-fill
    start_run(40'd9, 40'd3, 16'd1);
    step();
    step();
    trig_in = 1'b1;
    step();
    trig_in = 1'b0;
    check("R4 boundary trigger ignored", run_status, S_ARM);
    check("R4 boundary count", smp_count, 3);
    command(8'h00);

    // R2/R7 halt while armed with zero pre-count
    start_run(40'd50, 40'd0, 16'd1);
    check("R2 zero pre armed", run_status, S_ARM);
    repeat (3) step();
    command(8'h00);
    check("R7 halt from armed", run_status, S_IDLE);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule